// File: doc/BRIEF.md
# SIMT Warp Scheduler

This block keeps the live state of every warp in a small SIMT core and chooses which warp enters the pipeline each cycle. For each warp it holds an active flag, a stalled flag, one program counter shared by all of the warp's threads, and a thread mask. Each cycle it chooses one warp that is active and not stalled. It then presents that warp's id, PC and mask on the issue port. Writeback later uses the mask so that only enabled threads retire results.

Decode tells the scheduler when it has seen a control instruction. The scheduler then holds that warp back until the matching control update arrives. The update can set the warp's thread count, wake a group of warps at a common entry address, or enter a barrier. A barrier keeps warps parked until enough warps have arrived. A separate port lets a divergence stack replace a warp's mask directly. Another port lets a branch unit redirect a warp's PC.

Top module: `simt_warp_sched`

## Requirements
- R1: Each cycle at most one warp is issued, and only a warp that is active and not stalled. When no warp is eligible, `issue_valid` is low.
- R2: Selection is round robin. After warp w issues, the search for the next warp starts at w+1 and wraps to 0. Ineligible warps are skipped.
- R3: Each time a warp issues, its PC advances by `PC_STEP` (default 4). A `npc_valid` update replaces the PC of `npc_wid` and takes precedence over that advance.
- R4: The issue port carries the mask currently held for the issued warp.
- R5: Control op 1 (thread count) with count n sets the warp's mask to its lowest n threads, limited to all threads, and clears the warp's stall.
- R6: Control op 1 with count 0 deactivates the warp. The warp issues no more until it is woken by op 2.
- R7: Control op 2 (spawn) with count c and address a activates every inactive warp with index below c. Each such warp gets PC a and mask 0b0001. Warps that are already active keep their state. The caller's stall is cleared.
- R8: `stall_valid` stalls `stall_wid` from the next cycle. Control op 0 (resume) clears the stall.
- R9: Control op 3 (barrier) with id b and count c records the warp at barrier b and keeps it stalled. When the c-th arrival comes in, all warps recorded at b are released in the same cycle. Barrier b's counter then clears. Each barrier id counts on its own.
- R10: After reset only warp 0 is active. It has mask 0b0001 and PC `RESET_PC`, and no warp is stalled.
- R11: `ovr_valid` replaces the mask of `ovr_wid` with `ovr_mask`. A thread-count update to the same warp in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_valid | input | 1 | Decode saw a control instruction |
| stall_wid | input | WID_W | Warp to stall |
| ctl_valid | input | 1 | Control update valid |
| ctl_wid | input | WID_W | Warp that executed the control op |
| ctl_op | input | 2 | 0 resume, 1 thread count, 2 spawn, 3 barrier |
| ctl_count | input | CNT_W | Thread count, warp count or barrier count |
| ctl_addr | input | PC_W | Spawn entry address |
| ctl_bar_id | input | BID_W | Barrier id |
| npc_valid | input | 1 | PC redirect valid |
| npc_wid | input | WID_W | Warp to redirect |
| npc_addr | input | PC_W | New PC |
| ovr_valid | input | 1 | Mask override valid |
| ovr_wid | input | WID_W | Warp whose mask is replaced |
| ovr_mask | input | NT | Replacement mask |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_wid | output | WID_W | Issued warp |
| issue_pc | output | PC_W | PC of the issued warp |
| issue_mask | output | NT | Thread mask of the issued warp |

## Verification
The assertions assume the following about the inputs:
- A stall notice never names the same warp as a control update in the same cycle.
- Control updates come only from warps that are active.
- A barrier's count is never below the number of warps already waiting there.

The stimulus keeps to these rules. It drives at most one stall notice and one control update per cycle, and only for warps that are live. It sends each barrier arrival only after a stall notice for that warp. The bench's reference model applies updates in a fixed order: issue advance, redirect, mask override, control, stall.

// File: rtl/simt_warp_sched.sv
module simt_warp_sched #(
  parameter int NW = 4,
  parameter int NT = 4,
  parameter int NB = 2,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h8000_0000,
  parameter int PC_STEP = 4,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1,
  localparam int BID_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int CNT_W = $clog2(((NW > NT) ? NW : NT) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_valid,
  input  logic [WID_W-1:0] stall_wid,
  input  logic             ctl_valid,
  input  logic [WID_W-1:0] ctl_wid,
  input  logic [1:0]       ctl_op,
  input  logic [CNT_W-1:0] ctl_count,
  input  logic [PC_W-1:0]  ctl_addr,
  input  logic [BID_W-1:0] ctl_bar_id,
  input  logic             npc_valid,
  input  logic [WID_W-1:0] npc_wid,
  input  logic [PC_W-1:0]  npc_addr,
  input  logic             ovr_valid,
  input  logic [WID_W-1:0] ovr_wid,
  input  logic [NT-1:0]    ovr_mask,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_wid,
  output logic [PC_W-1:0]  issue_pc,
  output logic [NT-1:0]    issue_mask
);
  localparam logic [1:0] OP_RESUME = 2'd0, OP_TMASK = 2'd1, OP_SPAWN = 2'd2, OP_BARRIER = 2'd3;

  logic [NW-1:0]    active_q, stalled_q;
  logic [PC_W-1:0]  pc_q [NW];
  logic [NT-1:0]    mask_q [NW];
  logic [WID_W-1:0] rr_q;
  logic [CNT_W-1:0] arrive_q [NB];
  logic [NW-1:0]    wait_q [NB];

  wire [NW-1:0] eligible = active_q & ~stalled_q;

  logic             found;
  logic [WID_W-1:0] pick;
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NW; k++) begin
      if (!found && eligible[(int'(rr_q) + k) % NW]) begin
        found = 1'b1;
        pick  = WID_W'((int'(rr_q) + k) % NW);
      end
    end
  end

  assign issue_valid = found;
  assign issue_wid   = pick;
  assign issue_pc    = pc_q[pick];
  assign issue_mask  = found ? mask_q[pick] : '0;

  logic [NT-1:0] fill_mask;
  always_comb
    for (int t = 0; t < NT; t++) fill_mask[t] = (t < int'(ctl_count));

  wire              bar_hit     = ctl_valid && (ctl_op == OP_BARRIER);
  wire [CNT_W-1:0]  bar_sum     = arrive_q[ctl_bar_id] + 1'b1;
  wire              bar_release = bar_hit && (bar_sum >= ctl_count);
  wire [WID_W-1:0]  rr_next     = (int'(pick) == NW - 1) ? '0 : pick + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= NW'(1);
      stalled_q <= '0;
      rr_q      <= '0;
      for (int w = 0; w < NW; w++) begin
        pc_q[w]   <= RESET_PC;
        mask_q[w] <= (w == 0) ? NT'(1) : '0;
      end
      for (int b = 0; b < NB; b++) begin
        arrive_q[b] <= '0;
        wait_q[b]   <= '0;
      end
    end else begin
      if (found) begin
        rr_q       <= rr_next;
        pc_q[pick] <= pc_q[pick] + PC_W'(PC_STEP);
      end
      if (npc_valid) pc_q[npc_wid] <= npc_addr;
      if (ovr_valid) mask_q[ovr_wid] <= ovr_mask;
      if (ctl_valid) begin
        case (ctl_op)
          OP_RESUME: stalled_q[ctl_wid] <= 1'b0;
          OP_TMASK: begin
            mask_q[ctl_wid]    <= fill_mask;
            stalled_q[ctl_wid] <= 1'b0;
            if (ctl_count == '0) active_q[ctl_wid] <= 1'b0;
          end
          OP_SPAWN: begin
            stalled_q[ctl_wid] <= 1'b0;
            for (int v = 0; v < NW; v++) begin
              if (v < int'(ctl_count) && !active_q[v]) begin
                active_q[v] <= 1'b1;
                pc_q[v]     <= ctl_addr;
                mask_q[v]   <= NT'(1);
              end
            end
          end
          default: begin
            if (bar_release) begin
              for (int v = 0; v < NW; v++)
                if (wait_q[ctl_bar_id][v] || v == int'(ctl_wid)) stalled_q[v] <= 1'b0;
              arrive_q[ctl_bar_id] <= '0;
              wait_q[ctl_bar_id]   <= '0;
            end else begin
              stalled_q[ctl_wid]            <= 1'b1;
              arrive_q[ctl_bar_id]          <= bar_sum;
              wait_q[ctl_bar_id][ctl_wid]   <= 1'b1;
            end
          end
        endcase
      end
      if (stall_valid) stalled_q[stall_wid] <= 1'b1;
    end
  end

  assert_live_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> active_q[issue_wid] && !stalled_q[issue_wid]);

  assert_pc_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !(npc_valid && npc_wid == issue_wid)
    |=> pc_q[$past(issue_wid)] == $past(issue_pc) + PC_W'(PC_STEP));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid |=> stalled_q[$past(stall_wid)]);

  assert_tmask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && ctl_op == OP_TMASK && ctl_count == '0 |=> !active_q[$past(ctl_wid)]);

  assert_bar_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_release && !stall_valid |=> !stalled_q[$past(ctl_wid)] && arrive_q[$past(ctl_bar_id)] == '0);

  assert_mask_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> issue_mask == mask_q[issue_wid]);
endmodule

// File: tb/simt_warp_sched_test.sv
module simt_warp_sched_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic stall_valid = 0; logic [1:0] stall_wid = 0;
  logic ctl_valid = 0; logic [1:0] ctl_wid = 0, ctl_op = 0; logic [2:0] ctl_count = 0;
  logic [31:0] ctl_addr = 0; logic ctl_bar_id = 0;
  logic npc_valid = 0; logic [1:0] npc_wid = 0; logic [31:0] npc_addr = 0;
  logic ovr_valid = 0; logic [1:0] ovr_wid = 0; logic [3:0] ovr_mask = 0;
  logic issue_valid; logic [1:0] issue_wid; logic [31:0] issue_pc; logic [3:0] issue_mask;

  simt_warp_sched uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit m_act[4], m_stl[4]; int unsigned m_pc[4]; bit [3:0] m_mask[4];
  int m_rr; int m_cnt[2]; bit m_wait[2][4];
  int vectors = 0, fails = 0; bit done = 0; string req = "R10";

  function automatic int pick_warp();
    for (int k = 0; k < 4; k++) begin
      int w = (m_rr + k) % 4;
      if (m_act[w] && !m_stl[w]) return w;
    end
    return -1;
  endfunction

  task automatic compare();
    int w = pick_warp();
    vectors++;
    if (w < 0) begin
      if (issue_valid !== 1'b0) begin
        fails++; $display("FAIL %s: issue_valid=%b expected 0", req, issue_valid);
      end
    end else if (issue_valid !== 1'b1 || issue_wid !== 2'(w) || issue_pc !== m_pc[w] || issue_mask !== m_mask[w]) begin
      fails++;
      $display("FAIL %s: got v=%b w=%0d pc=%h m=%b expected v=1 w=%0d pc=%h m=%b",
               req, issue_valid, issue_wid, issue_pc, issue_mask, w, m_pc[w], m_mask[w]);
    end
  endtask

  task automatic model_step();
    int w = pick_warp();
    int c = int'(ctl_count);
    if (w >= 0) begin m_rr = (w + 1) % 4; m_pc[w] += 4; end
    if (npc_valid) m_pc[npc_wid] = npc_addr;
    if (ovr_valid) m_mask[ovr_wid] = ovr_mask;
    if (ctl_valid) begin
      if (ctl_op == 0) m_stl[ctl_wid] = 0;
      else if (ctl_op == 1) begin
        m_mask[ctl_wid] = (c >= 4) ? 4'hF : 4'((1 << c) - 1);
        m_stl[ctl_wid] = 0;
        if (c == 0) m_act[ctl_wid] = 0;
      end else if (ctl_op == 2) begin
        m_stl[ctl_wid] = 0;
        for (int v = 0; v < 4; v++)
          if (v < c && !m_act[v]) begin m_act[v] = 1; m_pc[v] = ctl_addr; m_mask[v] = 4'b0001; end
      end else begin
        m_wait[ctl_bar_id][ctl_wid] = 1;
        m_cnt[ctl_bar_id]++;
        if (m_cnt[ctl_bar_id] >= c) begin
          for (int v = 0; v < 4; v++) if (m_wait[ctl_bar_id][v]) begin m_stl[v] = 0; m_wait[ctl_bar_id][v] = 0; end
          m_cnt[ctl_bar_id] = 0;
        end else m_stl[ctl_wid] = 1;
      end
    end
    if (stall_valid) m_stl[stall_wid] = 1;
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      compare();
      stall_valid = 0; ctl_valid = 0; npc_valid = 0; ovr_valid = 0;
    end
  endtask

  task automatic ctl(input int w, input int op, input int cnt, input int addr = 0, input int bid = 0);
    ctl_valid = 1; ctl_wid = 2'(w); ctl_op = 2'(op); ctl_count = 3'(cnt);
    ctl_addr = 32'(addr); ctl_bar_id = 1'(bid);
    tick();
  endtask

  task automatic stall(input int w);
    stall_valid = 1; stall_wid = 2'(w); tick();
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin m_act[w] = (w == 0); m_stl[w] = 0; m_pc[w] = 32'h8000_0000; m_mask[w] = (w == 0) ? 4'b0001 : 4'b0000; end
    m_rr = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    for (int b = 0; b < 2; b++) for (int w = 0; w < 4; w++) m_wait[b][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();                                   // R10 reset state
    req = "R3"; tick(2);                         // R3 PC advance of warp 0
    req = "R7"; ctl(0, 2, 4, 32'h100);           // R7 spawn all warps
    req = "R2"; tick(8);                         // R2 rotation
    req = "R8"; stall(1); tick(4); ctl(1, 0, 0); tick(3);
    req = "R5"; ctl(2, 1, 3); tick(4); ctl(3, 1, 7); tick(4);
    req = "R3"; npc_valid = 1; npc_wid = 3; npc_addr = 32'h200; tick(5);
    req = "R11"; ovr_valid = 1; ovr_wid = 1; ovr_mask = 4'b1010; tick(4);
    req = "R11"; ovr_valid = 1; ovr_wid = 2; ovr_mask = 4'b1100; ctl(2, 1, 1); tick(4);
    req = "R9";
    stall(0); stall(1); stall(2); stall(3);
    ctl(0, 3, 3, 0, 0); ctl(3, 3, 2, 0, 1); ctl(1, 3, 3, 0, 0);
    tick(2);                                     // R1 all stalled: no issue
    ctl(2, 3, 3, 0, 0); tick(4);                 // R9 joint release
    stall(0); ctl(0, 3, 2, 0, 1); tick(4);       // R9 second id
    stall(1); ctl(1, 3, 2, 0, 0); stall(2); ctl(2, 3, 2, 0, 0); tick(4);
    req = "R6"; ctl(1, 1, 0); ctl(2, 1, 0); ctl(3, 1, 0); tick(4);
    req = "R1"; stall(0); tick(3);
    req = "R7"; ctl(0, 2, 2, 32'h300); tick(6);
    req = "R4"; tick(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule